// File: doc/BRIEF.md
# UART Receive Byte Queue

This block is the receive-side holding buffer of one serial channel. The bit-level receiver pushes each assembled byte into it. The CPU takes bytes out through reads of the receive data register, and each read becomes a one-cycle pop strobe. The queue holds up to four bytes in arrival order.

It produces two status flags for the status register: data-ready and full. It also gives the receiver a flow-control signal that says whether a new byte may be delivered. A line-break event from the receiver stores a zero byte under the normal push rules, and it sends a one-cycle break-change pulse to the interrupt logic.

The queue never drops a byte when it is full. Instead the newest stored byte is replaced. A read while the queue is empty returns zero and has no other effect. Storage is a circular buffer with read and write pointers and a count; bytes are not shifted between entries.

Top module: `uart_rx_queue`

## Requirements
- R1: Bytes leave the queue in the order they arrived, and up to DEPTH (default 4) bytes are held. While the queue is not empty, `pop_data` shows the oldest byte combinationally.
- R2: A push while the queue holds DEPTH bytes, with no pop in the same cycle, replaces the newest stored byte. The count stays at DEPTH, and the older bytes are kept in order.
- R3: After any accepted push, `rx_ready` is 1 on the next cycle. When the push leaves the count at DEPTH, `rx_full` is 1 on the next cycle.
- R4: A pop of a non-empty queue drops the oldest byte and clears `rx_full` on the next cycle, unless a push in the same cycle refills it to DEPTH. It clears `rx_ready` only when the queue becomes empty.
- R5: A pop of an empty queue presents `pop_data` = 0x00 and changes neither the contents nor the flags.
- R6: A break event (`brk_event`) pushes the byte 0x00 under the rules of R2 and R3. It makes `brk_pulse` 1 for exactly the next cycle. If `push_valid` is also 1 in that cycle, the data byte is discarded and only the zero byte is stored.
- R7: `can_accept` is 1 exactly when `rx_enable` is 1 and `rx_full` is 0.
- R8: A receiver clear (`rx_clear`) empties the queue, and `rx_ready` and `rx_full` are 0 on the next cycle. Any push, break or pop in the same cycle is ignored.
- R9: When a push and a pop fall in the same cycle on a non-empty queue, the pop is applied first and the push second. The count stays the same, and this holds at full as well.
- R10: After reset, `rx_ready`, `rx_full`, `brk_pulse` and `pop_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enabled, used only for flow control |
| rx_clear | input | 1 | Receiver-reset command strobe |
| push_valid | input | 1 | Receiver delivers a byte this cycle |
| push_data | input | DATA_W | Byte from the receiver |
| brk_event | input | 1 | Line break detected; stores a zero byte |
| pop | input | 1 | CPU read of the receive data register |
| pop_data | output | DATA_W | Oldest byte, or zero when empty |
| rx_ready | output | 1 | At least one byte is held |
| rx_full | output | 1 | Queue holds DEPTH bytes |
| can_accept | output | 1 | Receiver may deliver a new byte |
| brk_pulse | output | 1 | One-cycle break-change pulse |

## Verification
The bench fills the queue to every level from empty to full. At each level it applies every combination of data push, break and pop, with the receiver enabled and disabled. It then drains the queue byte by byte.

Each stored byte encodes its fill position, so the drain order separates true first-in first-out from a replacement of the wrong entry on overflow. It also separates the two possible orders of a same-cycle pop and push. A break applied together with a data push shows whether the zero byte wins. A pop one past empty shows that an empty read leaves the flags untouched. A final clear issued together with push and pop separates the clear's priority from plain draining.

// File: rtl/uart_rx_queue_pkg.sv
package uart_rx_queue_pkg;
  localparam int unsigned RXQ_DEPTH_DEF  = 4;
  localparam int unsigned RXQ_DATA_W_DEF = 8;

  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_APPEND  = 2'd1,
    WR_REPLACE = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/uart_rx_queue_ctrl.sv
module uart_rx_queue_ctrl
  import uart_rx_queue_pkg::*;
#(
  parameter int unsigned DEPTH = RXQ_DEPTH_DEF,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             pop_ok_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic             nonempty_o,
  output logic             fills_o,
  output logic             empties_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_mid;
  logic             pop_ok, upd_en;
  wr_mode_e         mode;

  always_comb begin
    pop_ok  = pop_i && (cnt_q != '0);
    cnt_mid = cnt_q - CNT_W'(pop_ok);
    rptr_d  = rptr_q + PTR_W'(pop_ok);
    wptr_d  = wptr_q;
    cnt_d   = cnt_mid;
    mode    = WR_NONE;
    if (push_i) begin
      if (cnt_mid == CNT_FULL) begin
        mode = WR_REPLACE;
      end else begin
        mode   = WR_APPEND;
        wptr_d = wptr_q + PTR_W'(1);
        cnt_d  = cnt_mid + CNT_W'(1);
      end
    end
    if (clr_i) begin
      mode   = WR_NONE;
      rptr_d = '0;
      wptr_d = '0;
      cnt_d  = '0;
    end
    upd_en = clr_i || pop_ok || push_i;
  end

  always_comb begin
    wr_en_o   = (mode != WR_NONE);
    wr_addr_o = (mode == WR_REPLACE) ? (wptr_q - PTR_W'(1)) : wptr_q;
    rd_addr_o = rptr_q;
    pop_ok_o  = pop_ok && !clr_i;
    nonempty_o = (cnt_q != '0);
    fills_o   = !clr_i && push_i && (cnt_d == CNT_FULL);
    empties_o = !clr_i && pop_ok && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_FULL && push_i && !pop_i && !clr_i) |=> (cnt_q == CNT_FULL && $stable(wptr_q)));
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop_i && !push_i && !clr_i) |=> (cnt_q == '0 && $stable(rptr_q)));
  p_same_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && pop_i && push_i && !clr_i) |=> $stable(cnt_q));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/uart_rx_queue_store.sv
module uart_rx_queue_store
  import uart_rx_queue_pkg::*;
#(
  parameter int unsigned DEPTH  = RXQ_DEPTH_DEF,
  parameter int unsigned DATA_W = RXQ_DATA_W_DEF,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic ent_en;
    assign ent_en = wr_en_i && (wr_addr_i == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= '0;
      end else if (ent_en) begin
        mem_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/uart_rx_queue_flags.sv
module uart_rx_queue_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic push_i,
  input  logic pop_ok_i,
  input  logic fills_i,
  input  logic empties_i,
  input  logic brk_i,
  output logic rdy_o,
  output logic full_o,
  output logic brk_pulse_o
);
  logic rdy_q, rdy_d, full_q, full_d, brk_q, brk_d;

  always_comb begin
    rdy_d  = rdy_q;
    full_d = full_q;
    if (pop_ok_i)  full_d = 1'b0;
    if (empties_i) rdy_d  = 1'b0;
    if (push_i)    rdy_d  = 1'b1;
    if (fills_i)   full_d = 1'b1;
    if (clr_i) begin
      rdy_d  = 1'b0;
      full_d = 1'b0;
    end
    brk_d = brk_i && !clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      rdy_q  <= rdy_d;
      full_q <= full_d;
      brk_q  <= brk_d;
    end
  end

  assign rdy_o       = rdy_q;
  assign full_o      = full_q;
  assign brk_pulse_o = brk_q;

  p_push_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i) |=> rdy_q);
  p_pop_unfull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok_i && !push_i && !clr_i) |=> !full_q);
  p_brk_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i && !clr_i) |=> (brk_q && rdy_q));
  p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!rdy_q && !full_q));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rx_queue_pkg::*;
#(
  parameter int unsigned DEPTH  = RXQ_DEPTH_DEF,
  parameter int unsigned DATA_W = RXQ_DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              rx_clear,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              brk_event,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              rx_ready,
  output logic              rx_full,
  output logic              can_accept,
  output logic              brk_pulse
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic              push_any, pop_ok, wr_en, nonempty, fills, empties;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  assign push_any = push_valid || brk_event;
  assign wr_data  = brk_event ? '0 : push_data;

  uart_rx_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (rx_clear),
    .push_i     (push_any),
    .pop_i      (pop),
    .pop_ok_o   (pop_ok),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .rd_addr_o  (rd_addr),
    .nonempty_o (nonempty),
    .fills_o    (fills),
    .empties_o  (empties)
  );

  uart_rx_queue_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  uart_rx_queue_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (rx_clear),
    .push_i      (push_any),
    .pop_ok_i    (pop_ok),
    .fills_i     (fills),
    .empties_i   (empties),
    .brk_i       (brk_event),
    .rdy_o       (rx_ready),
    .full_o      (rx_full),
    .brk_pulse_o (brk_pulse)
  );

  assign pop_data   = nonempty ? rd_data : '0;
  assign can_accept = rx_enable && !rx_full;

  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> (pop_data == '0));
  p_break_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_event && !rx_clear && !rx_ready) |=> (pop_data == '0 && rx_ready));
endmodule

// File: tb/uart_rx_queue_bench.sv
module uart_rx_queue_bench;
  localparam int CLK_P = 10;

  logic       clk, rst_n, rx_enable, rx_clear, push_valid, brk_event, pop;
  logic [7:0] push_data, pop_data;
  logic       rx_ready, rx_full, can_accept, brk_pulse;

  int n_chk, n_bad;
  bit finished;

  int m_q [4];
  int m_cnt;
  bit m_rdy, m_full, m_brk;

  uart_rx_queue u_uart_rx_queue (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_clear(rx_clear),
    .push_valid(push_valid), .push_data(push_data), .brk_event(brk_event),
    .pop(pop), .pop_data(pop_data), .rx_ready(rx_ready), .rx_full(rx_full),
    .can_accept(can_accept), .brk_pulse(brk_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(bit pu, int d, bit po, bit br, bit cl);
    m_brk = br && !cl;
    if (cl) begin
      m_cnt = 0; m_rdy = 0; m_full = 0;
      return;
    end
    if (po && m_cnt > 0) begin
      for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
      m_cnt--;
      m_full = 0;
      if (m_cnt == 0) m_rdy = 0;
    end
    if (pu || br) begin
      if (m_cnt == 4) m_q[3] = br ? 0 : d;
      else begin
        m_q[m_cnt] = br ? 0 : d;
        m_cnt++;
      end
      m_rdy = 1;
      if (m_cnt == 4) m_full = 1;
    end
  endtask

  // Inputs are driven at the falling edge; outputs are checked before the next rising edge.
  task automatic cycle(bit pu, int d, bit po, bit br, bit cl, string req);
    push_valid = pu; push_data = 8'(d); pop = po; brk_event = br; rx_clear = cl;
    #1;
    check({req, " pop_data"}, int'(pop_data), (m_cnt > 0) ? m_q[0] : 0);
    model_step(pu, d, po, br, cl);
    @(posedge clk);
    @(negedge clk);
    push_valid = 0; pop = 0; brk_event = 0; rx_clear = 0;
    #1;
  endtask

  task automatic check_flags(string req);
    check({req, " rx_ready"}, int'(rx_ready), int'(m_rdy));
    check({req, " rx_full"}, int'(rx_full), int'(m_full));
    check({"R7 can_accept"}, int'(can_accept), int'(rx_enable && m_full == 0));
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    m_cnt = 0; m_rdy = 0; m_full = 0; m_brk = 0;
    rst_n = 0; rx_enable = 0; rx_clear = 0; push_valid = 0; push_data = 0;
    brk_event = 0; pop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R10 rx_ready", int'(rx_ready), 0);
    check("R10 rx_full", int'(rx_full), 0);
    check("R10 brk_pulse", int'(brk_pulse), 0);
    check("R10 pop_data", int'(pop_data), 0);

    for (int en = 0; en < 2; en++) begin
      for (int lvl = 0; lvl <= 4; lvl++) begin
        for (int op = 0; op < 8; op++) begin
          rx_enable = en[0];
          cycle(0, 0, 0, 0, 1, "R8");
          check_flags("R8");
          for (int k = 0; k < lvl; k++) begin
            cycle(1, 16*lvl + k + 1, 0, 0, 0, "R1");
            check_flags("R3");
          end
          // op bit0 = data push, bit1 = pop, bit2 = break
          cycle(op[0], 8'hA0 + op, op[1], op[2], 0, "R9");
          check_flags((op[1] && lvl == 0) ? "R5" : (lvl == 4 && op[0]) ? "R2" : "R4");
          check("R6 brk_pulse", int'(brk_pulse), int'(m_brk));
          while (m_cnt > 0) begin
            cycle(0, 0, 1, 0, 0, (lvl == 4) ? "R2" : "R1");
            check_flags("R4");
          end
          cycle(0, 0, 1, 0, 0, "R5");
          check_flags("R5");
        end
      end
    end

    // clear overrides concurrent push, break and pop
    cycle(1, 8'h11, 0, 0, 0, "R1");
    cycle(1, 8'h22, 0, 0, 0, "R1");
    cycle(1, 8'h33, 1, 1, 1, "R8");
    check_flags("R8");
    check("R8 brk_pulse", int'(brk_pulse), 0);
    check("R8 pop_data", int'(pop_data), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule